// File: doc/BRIEF.md
# Dual-Mode Complex Multiplier

This block forms the product of two complex operands, x = a + jb and y = c + jd, each given as signed two's-complement real and imaginary parts. Four real multipliers produce the cross products. One subtract stage forms the real result and one add stage forms the imaginary result. The datapath is pipelined in two register stages. The first stage holds the products and the second holds the combined results.

A per-sample mode input picks between two uses of the same datapath. In wide mode the full operand width forms one complex product. In narrow mode each operand word is split into two half-width lanes. Each lane computes its own complex product, and no arithmetic crosses from one lane to the other. The mode travels down the pipeline with its operands, so consecutive samples may use different modes.

Top module: `cplx_mul_dual`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, that edge clears `out_valid`, `prod_re` and `prod_im` to zero.
- R2: In wide mode (`mode_narrow` = 0), `prod_re` equals a·c − b·d. Here a = `x_re`, b = `x_im`, c = `y_re` and d = `y_im`, all signed. The result is exact in 2W+1 bits and is sign-extended to the 2W+2-bit port.
- R3: In wide mode, `prod_im` equals a·d + b·c, with the same widths as R2.
- R4: In narrow mode (`mode_narrow` = 1), lane 0 takes bits [W/2-1:0] and lane 1 takes bits [W-1:W/2] of each operand as signed W/2-bit values. Lane k returns its real part a·c − b·d in `prod_re[k*(W+1) +: W+1]` and its imaginary part a·d + b·c in `prod_im[k*(W+1) +: W+1]`.
- R5: In narrow mode, each lane's result depends only on that lane's operand bits. Holding one lane's operands fixed keeps its result fixed, whatever the other lane carries.
- R6: `out_valid` is high exactly two clock cycles after a cycle with `in_valid` high, and at no other time.
- R7: While `out_valid` is low, `prod_re` and `prod_im` keep their previous values.
- R8: The mode is captured with the operands of each sample. Back-to-back samples that alternate between modes each give the correct result for their own mode, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands on this cycle are a sample |
| mode_narrow | input | 1 | 0: one W-bit product, 1: two W/2-bit lane products |
| x_re | input | W | Real part a of the first operand |
| x_im | input | W | Imaginary part b of the first operand |
| y_re | input | W | Real part c of the second operand |
| y_im | input | W | Imaginary part d of the second operand |
| out_valid | output | 1 | Results below belong to a sample |
| prod_re | output | 2W+2 | Real part of the result (wide value or two lanes) |
| prod_im | output | 2W+2 | Imaginary part of the result (wide value or two lanes) |

## Verification
The bench builds the block with W = 6, which gives 3-bit lanes. With that width every operand combination of a narrow lane can be applied: the bench uses 4096 lane patterns, with the other lane moving at the same time. Wide mode is swept over every pair of real parts, with the imaginary parts tied to them. A full cross of the extreme and near-extreme operand values is also applied, including the most negative value times itself. Short fixed-lane and mode-alternating streams cover lane isolation and the per-sample mode, and idle stretches cover the holding of the outputs.

// File: rtl/cmul_pkg.sv
`timescale 1ns/1ps
// Shared types for the dual-mode complex multiplier.
// Assumes: nothing beyond the standard two's-complement encoding.
package cmul_pkg;

    // Datapath configuration carried with every sample.
    typedef enum logic {
        MODE_WIDE   = 1'b0,
        MODE_NARROW = 1'b1
    } cmul_mode_e;

endpackage

// File: rtl/cmul_split_mult.sv
`timescale 1ns/1ps
// Registered signed multiplier that computes either one W x W product or
// two independent W/2 x W/2 lane products, packed low lane first.
// Assumes: W is even; en qualifies a new sample, otherwise the register holds.
module cmul_split_mult
    import cmul_pkg::*;
#(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  cmul_mode_e   mode,
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [2*W-1:0] prod
);
    localparam int N   = W / 2;
    localparam int PW  = 2 * W;
    localparam int NPW = 2 * N;
    localparam int LANES = 2;

    logic signed [PW-1:0] wide_p;
    logic        [PW-1:0] narrow_p;

    // Full-width signed product.
    always_comb wide_p = $signed(x) * $signed(y);

    // Per-lane signed products; no carry reaches the neighbouring lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic signed [NPW-1:0] lane_p;
        always_comb lane_p = $signed(x[g*N +: N]) * $signed(y[g*N +: N]);
        assign narrow_p[g*NPW +: NPW] = lane_p;
    end

    // Product register: the selected variant is stored when a sample arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod <= '0;
        end else if (en) begin
            prod <= (mode == MODE_NARROW) ? narrow_p : wide_p;
        end
    end

endmodule

// File: rtl/cmul_combine.sv
`timescale 1ns/1ps
// Combinational add or subtract of two packed products, wide or per lane.
// Wide results are exact in 2W+1 bits and sign-extended to 2W+2; each lane
// result is exact in W+1 bits and occupies its own field.
// Assumes: W is even; operands come from cmul_split_mult in the same mode.
module cmul_combine
    import cmul_pkg::*;
#(
    parameter int W        = 18,
    parameter bit SUBTRACT = 1'b0
) (
    input  cmul_mode_e      mode,
    input  logic [2*W-1:0]  p_first,
    input  logic [2*W-1:0]  p_second,
    output logic [2*W+1:0]  result
);
    localparam int N     = W / 2;
    localparam int NPW   = 2 * N;
    localparam int LW    = NPW + 1;
    localparam int RW    = 2 * W + 1;
    localparam int OW    = 2 * LW;
    localparam int LANES = 2;

    logic signed [RW-1:0] wide_r;
    logic        [OW-1:0] narrow_r;

    // Wide combine over the full products.
    if (SUBTRACT) begin : g_wide_sub
        always_comb wide_r = $signed(p_first) - $signed(p_second);
    end else begin : g_wide_add
        always_comb wide_r = $signed(p_first) + $signed(p_second);
    end

    // Lane combine, each lane one bit wider than its products.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic signed [LW-1:0] lane_r;
        if (SUBTRACT) begin : g_sub
            assign lane_r = $signed(p_first[g*NPW +: NPW]) - $signed(p_second[g*NPW +: NPW]);
        end else begin : g_add
            assign lane_r = $signed(p_first[g*NPW +: NPW]) + $signed(p_second[g*NPW +: NPW]);
        end
        assign narrow_r[g*LW +: LW] = lane_r;
    end

    // Output select by the sample's mode.
    always_comb begin
        if (mode == MODE_NARROW) begin
            result = narrow_r;
        end else begin
            result = {{(OW-RW){wide_r[RW-1]}}, wide_r};
        end
    end

endmodule

// File: rtl/cplx_mul_dual.sv
`timescale 1ns/1ps
// Dual-mode complex multiplier: (x_re + j x_im) * (y_re + j y_im).
// Stage 1 registers four products, stage 2 registers real and imaginary sums.
// Assumes: W is even; mode_narrow is sampled together with the operands.
module cplx_mul_dual
    import cmul_pkg::*;
#(
    parameter int W = 18
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic           mode_narrow,
    input  logic [W-1:0]   x_re,
    input  logic [W-1:0]   x_im,
    input  logic [W-1:0]   y_re,
    input  logic [W-1:0]   y_im,
    output logic           out_valid,
    output logic [2*W+1:0] prod_re,
    output logic [2*W+1:0] prod_im
);
    localparam int PW    = 2 * W;
    localparam int OW    = 2 * W + 2;
    localparam int NMULT = 4;
    // Multiplier roles: 0 = a*c, 1 = b*d, 2 = a*d, 3 = b*c.
    localparam int M_AC = 0;
    localparam int M_BD = 1;
    localparam int M_AD = 2;
    localparam int M_BC = 3;

    cmul_mode_e      in_mode;
    cmul_mode_e      s1_mode;
    logic            s1_valid;
    logic [W-1:0]    mul_x [NMULT];
    logic [W-1:0]    mul_y [NMULT];
    logic [PW-1:0]   prod  [NMULT];
    logic [OW-1:0]   sum_re;
    logic [OW-1:0]   sum_im;

    assign in_mode = mode_narrow ? MODE_NARROW : MODE_WIDE;

    // Operand routing to the four multipliers.
    assign mul_x[M_AC] = x_re;  assign mul_y[M_AC] = y_re;
    assign mul_x[M_BD] = x_im;  assign mul_y[M_BD] = y_im;
    assign mul_x[M_AD] = x_re;  assign mul_y[M_AD] = y_im;
    assign mul_x[M_BC] = x_im;  assign mul_y[M_BC] = y_re;

    for (genvar i = 0; i < NMULT; i++) begin : g_mult
        cmul_split_mult #(.W(W)) u_mult (
            .clk  (clk),
            .rst_n(rst_n),
            .en   (in_valid),
            .mode (in_mode),
            .x    (mul_x[i]),
            .y    (mul_y[i]),
            .prod (prod[i])
        );
    end

    // Stage-1 control: valid and mode travel beside the products.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_mode  <= MODE_WIDE;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_mode <= in_mode;
            end
        end
    end

    cmul_combine #(.W(W), .SUBTRACT(1'b1)) u_real (
        .mode    (s1_mode),
        .p_first (prod[M_AC]),
        .p_second(prod[M_BD]),
        .result  (sum_re)
    );

    cmul_combine #(.W(W), .SUBTRACT(1'b0)) u_imag (
        .mode    (s1_mode),
        .p_first (prod[M_AD]),
        .p_second(prod[M_BC]),
        .result  (sum_im)
    );

    // Stage-2 output register: results update only for a real sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            prod_re   <= '0;
            prod_im   <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                prod_re <= sum_re;
                prod_im <= sum_im;
            end
        end
    end

endmodule

// File: rtl/cplx_mul_dual_chk.sv
`timescale 1ns/1ps
// Property checker for cplx_mul_dual, attached by bind below.
// Assumes: the same W as the bound instance; observes ports only.
module cplx_mul_dual_chk #(
    parameter int W = 18
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic           mode_narrow,
    input logic [W-1:0]   x_re,
    input logic [W-1:0]   x_im,
    input logic [W-1:0]   y_re,
    input logic [W-1:0]   y_im,
    input logic           out_valid,
    input logic [2*W+1:0] prod_re,
    input logic [2*W+1:0] prod_im
);
    localparam int N  = W / 2;
    localparam int RW = 2 * W + 1;
    localparam int LW = 2 * N + 1;

    // Wide dot term p*q -/+ r*s, exact in RW bits.
    function automatic logic signed [RW-1:0] wide_term(input logic [W-1:0] p, q, r, s, input bit sub);
        logic signed [RW-1:0] m1, m2;
        m1 = $signed(p) * $signed(q);
        m2 = $signed(r) * $signed(s);
        return sub ? (m1 - m2) : (m1 + m2);
    endfunction

    // Lane dot term p*q -/+ r*s, exact in LW bits.
    function automatic logic signed [LW-1:0] lane_term(input logic [N-1:0] p, q, r, s, input bit sub);
        logic signed [LW-1:0] m1, m2;
        m1 = $signed(p) * $signed(q);
        m2 = $signed(r) * $signed(s);
        return sub ? (m1 - m2) : (m1 + m2);
    endfunction

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && prod_re == '0 && prod_im == '0));

    assert_wide_real_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(mode_narrow, 2)) |->
        $signed(prod_re) == wide_term($past(x_re, 2), $past(y_re, 2), $past(x_im, 2), $past(y_im, 2), 1'b1));

    assert_wide_imag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(mode_narrow, 2)) |->
        $signed(prod_im) == wide_term($past(x_re, 2), $past(y_im, 2), $past(x_im, 2), $past(y_re, 2), 1'b0));

    // Lane 0 from its own operand bits only (R4, R5).
    assert_lane_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(mode_narrow, 2)) |->
        ($signed(prod_re[LW-1:0]) == lane_term($past(x_re[N-1:0], 2), $past(y_re[N-1:0], 2),
                                               $past(x_im[N-1:0], 2), $past(y_im[N-1:0], 2), 1'b1) &&
         $signed(prod_im[LW-1:0]) == lane_term($past(x_re[N-1:0], 2), $past(y_im[N-1:0], 2),
                                               $past(x_im[N-1:0], 2), $past(y_re[N-1:0], 2), 1'b0)));

    // Lane 1 from its own operand bits only (R4, R5).
    assert_lane_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(mode_narrow, 2)) |->
        ($signed(prod_re[2*LW-1:LW]) == lane_term($past(x_re[W-1:N], 2), $past(y_re[W-1:N], 2),
                                                  $past(x_im[W-1:N], 2), $past(y_im[W-1:N], 2), 1'b1) &&
         $signed(prod_im[2*LW-1:LW]) == lane_term($past(x_re[W-1:N], 2), $past(y_im[W-1:N], 2),
                                                  $past(x_im[W-1:N], 2), $past(y_re[W-1:N], 2), 1'b0)));

    assert_valid_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);

    assert_no_spurious_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ##1 !out_valid);

    assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(prod_re) && $stable(prod_im)));

endmodule

bind cplx_mul_dual cplx_mul_dual_chk #(.W(W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .mode_narrow(mode_narrow),
    .x_re       (x_re),
    .x_im       (x_im),
    .y_re       (y_re),
    .y_im       (y_im),
    .out_valid  (out_valid),
    .prod_re    (prod_re),
    .prod_im    (prod_im)
);

// File: tb/cplx_mul_dual_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench for cplx_mul_dual with W = 6 (3-bit lanes).
module cplx_mul_dual_tb_top;
    localparam int W  = 6;
    localparam int N  = W / 2;
    localparam int LW = 2 * N + 1;
    localparam int OW = 2 * W + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          mode_narrow = 1'b0;
    logic [W-1:0]  x_re = '0, x_im = '0, y_re = '0, y_im = '0;
    logic          out_valid;
    logic [OW-1:0] prod_re, prod_im;

    typedef struct {
        bit           narrow;
        logic [W-1:0] ar, ai, br, bi;
        string        tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    cplx_mul_dual #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode_narrow(mode_narrow),
        .x_re(x_re), .x_im(x_im), .y_re(y_re), .y_im(y_im),
        .out_valid(out_valid), .prod_re(prod_re), .prod_im(prod_im)
    );

    function automatic longint sx(longint v, int w);
        longint t;
        t = v <<< (64 - w);
        return t >>> (64 - w);
    endfunction

    function automatic longint field(longint v, int lo, int w);
        return sx((v >> lo) & ((64'sd1 <<< w) - 1), w);
    endfunction

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Result checker: compares each output sample with the next expected entry.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (q.size() == 0) begin
                check(1'b0, "R6", "out_valid without sample", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (!e.narrow) begin
                    longint a, b, c, d, er, ei;
                    a = sx(longint'(e.ar), W); b = sx(longint'(e.ai), W);
                    c = sx(longint'(e.br), W); d = sx(longint'(e.bi), W);
                    er = a * c - b * d;
                    ei = a * d + b * c;
                    check(sx(longint'(prod_re), OW) == er, e.tag, "wide real", sx(longint'(prod_re), OW), er);
                    check(sx(longint'(prod_im), OW) == ei, e.tag, "wide imag", sx(longint'(prod_im), OW), ei);
                end else begin
                    for (int g = 0; g < 2; g++) begin
                        longint a, b, c, d, er, ei, ar_, ai_;
                        a = field(longint'(e.ar), g * N, N); b = field(longint'(e.ai), g * N, N);
                        c = field(longint'(e.br), g * N, N); d = field(longint'(e.bi), g * N, N);
                        er = a * c - b * d;
                        ei = a * d + b * c;
                        ar_ = field(longint'(prod_re), g * LW, LW);
                        ai_ = field(longint'(prod_im), g * LW, LW);
                        check(ar_ == er, e.tag, (g == 0) ? "lane0 real" : "lane1 real", ar_, er);
                        check(ai_ == ei, e.tag, (g == 0) ? "lane0 imag" : "lane1 imag", ai_, ei);
                    end
                end
            end
        end
    end

    task automatic send(bit nar, logic [W-1:0] ar, logic [W-1:0] ai,
                        logic [W-1:0] br, logic [W-1:0] bi, string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1; mode_narrow = nar;
        x_re = ar; x_im = ai; y_re = br; y_im = bi;
        e.narrow = nar; e.ar = ar; e.ai = ai; e.br = br; e.bi = bi; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R6 watchdog expired actual=%0d expected=%0d", q.size(), 0);
        summary();
        $finish;
    end

    initial begin
        logic [OW-1:0] held_re, held_im;
        int corner[5] = '{32, 31, 0, 63, 1};

        // R1: reset clears outputs even with activity on the inputs.
        in_valid = 1'b1; x_re = 6'd21; x_im = 6'd42; y_re = 6'd13; y_im = 6'd7;
        repeat (5) @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
        check(prod_re == '0 && prod_im == '0, "R1", "results in reset", prod_re | prod_im, 0);
        rst_n = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);

        // R6: a single sample appears exactly two cycles later, for one cycle.
        send(1'b0, 6'd5, 6'd60, 6'd33, 6'd2, "R6");
        @(negedge clk); in_valid = 1'b0;
        check(out_valid == 1'b0, "R6", "valid after 1 cycle", out_valid, 0);
        @(negedge clk);
        check(out_valid == 1'b1, "R6", "valid after 2 cycles", out_valid, 1);
        @(negedge clk);
        check(out_valid == 1'b0, "R6", "valid after 3 cycles", out_valid, 0);
        idle(2);

        // R2 R3: wide sweep over every pair of real parts.
        for (int a = 0; a < 64; a++)
            for (int c = 0; c < 64; c++)
                send(1'b0, W'(a), W'(a * 5 + c * 3), W'(c), W'(a ^ c), "R2 R3 sweep");

        // R2 R3: cross of extreme operand values.
        for (int i = 0; i < 5; i++)
            for (int j = 0; j < 5; j++)
                for (int k = 0; k < 5; k++)
                    for (int l = 0; l < 5; l++)
                        send(1'b0, W'(corner[i]), W'(corner[j]), W'(corner[k]), W'(corner[l]), "R2 R3 corner");

        // R4: every lane-0 pattern, lane 1 moving at the same time.
        for (int i = 0; i < 4096; i++) begin
            int h;
            h = (i * 7 + 13) & 4095;
            send(1'b1, W'({h[2:0], i[2:0]}), W'({h[5:3], i[5:3]}),
                       W'({h[8:6], i[8:6]}), W'({h[11:9], i[11:9]}), "R4");
        end

        // R5: lane 0 fixed at extremes while lane 1 sweeps.
        for (int i = 0; i < 512; i++)
            send(1'b1, W'({i[2:0], 3'd4}), W'({i[5:3], 3'd4}),
                       W'({i[8:6], 3'd4}), W'({i[2:0] ^ i[8:6], 3'd3}), "R5");

        // R8: modes alternate on back-to-back samples.
        for (int k = 0; k < 256; k++)
            send(k[0], W'(k * 11 + 3), W'(k * 29 + 7), W'(k * 5 + 40), W'(k * 17 + 1), "R8");

        idle(4);

        // R7: outputs hold while no sample is in flight.
        held_re = prod_re; held_im = prod_im;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            in_valid = 1'b0; mode_narrow = i[0];
            x_re = W'(i * 9 + 1); x_im = W'(i * 23); y_re = W'(63 - i); y_im = W'(i * 3 + 32);
            check(out_valid == 1'b0, "R7", "valid while idle", out_valid, 0);
            check(prod_re == held_re && prod_im == held_im, "R7", "results held",
                  longint'(prod_re), longint'(held_re));
        end

        check(q.size() == 0, "R6", "samples left unanswered", q.size(), 0);
        summary();
        $finish;
    end

endmodule